// File: doc/BRIEF.md
# RTC Interrupt Flag and Enable Controller

This block sits between the event outputs of a real-time clock core and the host. The core raises three one-clock event strobes: alarm match, periodic tick and update-cycle-ended. Each strobe sets a sticky flag, whether or not interrupts are enabled for that source. The host sets a per-source enable mask through a control register. The active-low interrupt line is driven low while any source has both its flag and its enable set.

A status register reports the three flags and a summary bit that mirrors the interrupt line. Reading it returns a snapshot taken at the read strobe and clears every flag at once. A small state machine then opens a hold window: events that arrive in the read cycle or during the window are parked in a pending register. They become flags only when the window closes, so the snapshot the host is reading stays consistent. The machine has two states. ST_OPEN passes events straight to the flags. ST_HOLD parks them. Three transitions connect them. T_READ goes from ST_OPEN to ST_HOLD on a status read. T_RESTART goes from ST_HOLD to ST_HOLD on another status read and restarts the window count. T_RELEASE goes from ST_HOLD to ST_OPEN when the count ends, and merges the pending events into the flags.

A separate read-only register carries a time-valid bit. A battery-low input clears that bit. A host read of that register sets it.

Top module: `rtcirq_ctrl`

## Requirements
- R1: An event strobe (alarm, periodic or update-ended) sets that source's flag on the next clock edge, independent of its enable bit, provided no hold window is open and no status read happens in that cycle.
- R2: The control register holds the enables at bit 6 (periodic), bit 5 (alarm) and bit 4 (update-ended). Writes load these three bits. Reads return them with every other bit 0.
- R3: `irq_n` is 0 exactly when at least one source has both flag and enable set, and is 1 out of reset.
- R4: A status read returns bit 7 = summary (1 when `irq_n` is low at the read edge), bit 6 = periodic flag, bit 5 = alarm flag, bit 4 = update-ended flag, and bits 3:0 = 0.
- R5: A status read clears every flag on the read edge. `rdata` shows the snapshot from the cycle after the read strobe and holds it until the next read.
- R6: Events in the status read cycle, and in the following HOLD_LEN cycles, are held pending. They are set as flags at the end of that window. A further status read inside the window restarts it.
- R7: Writing an enable bit to 1 while its flag is already set drives `irq_n` low in the next cycle.
- R8: The valid register reads bit 7 = valid and bits 6:0 = 0. It resets to 0, and host writes to it have no effect.
- R9: A read of the valid register returns the current value and then sets the valid bit. `batt_low` clears it on the next edge and wins over a simultaneous read.
- R10: Reads of an unmapped address return 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_alarm | input | 1 | Alarm match strobe, one clock |
| evt_periodic | input | 1 | Periodic tick strobe, one clock |
| evt_update | input | 1 | Update-cycle-ended strobe, one clock |
| batt_low | input | 1 | Battery low indication, clears the valid bit |
| rd_stb | input | 1 | Single-cycle host read strobe |
| wr_stb | input | 1 | Single-cycle host write strobe |
| addr | input | ADDR_W | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data, valid from the cycle after `rd_stb` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with HOLD_LEN = 3 and the default register addresses. The three-cycle window allows events to be placed in the read cycle itself, inside the window and at its last edge. A second status read can then land before release and show the restart, which a default-length window would make hard to tell apart from a plain release. Random traffic over all four addresses, with battery-low pulses, is compared cycle by cycle against a bench-side register model.

// File: rtl/rtcirq_pkg.sv
package rtcirq_pkg;

    // number of interrupt sources and their index inside a source vector
    localparam int NSRC    = 3;
    localparam int SRC_UPD = 0;
    localparam int SRC_ALM = 1;
    localparam int SRC_PER = 2;

    // register layout: source i lives at bit FIELD_LSB + i
    localparam int DATA_W    = 8;
    localparam int FIELD_LSB = 4;
    localparam int SUM_BIT   = 7;
    localparam int VALID_BIT = 7;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [0:0] {
        ST_OPEN = 1'b0,
        ST_HOLD = 1'b1
    } hold_st_e;

endpackage

// File: rtl/rtcirq_hold_fsm.sv
module rtcirq_hold_fsm #(
    parameter int HOLD_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    output logic holding,
    output logic release_now
);
    import rtcirq_pkg::*;

    localparam int CW = (HOLD_LEN < 2) ? 1 : $clog2(HOLD_LEN);
    localparam logic [CW-1:0] LAST = CW'(HOLD_LEN - 1);

    hold_st_e       st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_OPEN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state: T_READ, T_RESTART, T_RELEASE
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_OPEN: begin
                if (stat_rd) begin
                    st_d  = ST_HOLD;
                    cnt_d = '0;
                end
            end
            ST_HOLD: begin
                if (stat_rd) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    st_d  = ST_OPEN;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                st_d  = ST_OPEN;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        holding     = (st_q == ST_HOLD);
        release_now = (st_q == ST_HOLD) && !stat_rd && (cnt_q == LAST);
    end

endmodule

// File: rtl/rtcirq_flag_bank.sv
module rtcirq_flag_bank
    import rtcirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t evt,
    input  logic     clear,
    input  logic     holding,
    input  logic     release_now,
    output src_vec_t flags
);

    src_vec_t flag_q;
    src_vec_t pend_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
                pend_q[i] <= 1'b0;
            end else begin
                // flag: cleared by a status read, merged on release,
                // frozen while the hold window is open
                if (clear) begin
                    flag_q[i] <= 1'b0;
                end else if (release_now) begin
                    flag_q[i] <= flag_q[i] | pend_q[i] | evt[i];
                end else if (!holding) begin
                    flag_q[i] <= flag_q[i] | evt[i];
                end

                // pending: collects events while reads are in progress
                if (release_now) begin
                    pend_q[i] <= 1'b0;
                end else if (holding || clear) begin
                    pend_q[i] <= pend_q[i] | evt[i];
                end
            end
        end
    end

    assign flags = flag_q;

endmodule

// File: rtl/rtcirq_valid_reg.sv
module rtcirq_valid_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic batt_low,
    input  logic valid_rd,
    output logic valid
);

    logic valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (batt_low) begin
            valid_q <= 1'b0;
        end else if (valid_rd) begin
            valid_q <= 1'b1;
        end
    end

    assign valid = valid_q;

endmodule

// File: rtl/rtcirq_ctrl.sv
module rtcirq_ctrl #(
    parameter int ADDR_W   = 2,
    parameter int A_CTRL   = 1,
    parameter int A_STAT   = 2,
    parameter int A_VALID  = 3,
    parameter int HOLD_LEN = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        evt_alarm,
    input  logic                        evt_periodic,
    input  logic                        evt_update,
    input  logic                        batt_low,
    input  logic                        rd_stb,
    input  logic                        wr_stb,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [rtcirq_pkg::DATA_W-1:0] wdata,
    output logic [rtcirq_pkg::DATA_W-1:0] rdata,
    output logic                        irq_n
);
    import rtcirq_pkg::*;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] ADR_STAT  = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] ADR_VALID = ADDR_W'(A_VALID);
    localparam int FIELD_MSB = FIELD_LSB + NSRC - 1;

    src_vec_t              evt_vec;
    src_vec_t              flags_w;
    src_vec_t              en_q;
    logic                  stat_rd, ctrl_wr, valid_rd;
    logic                  holding, release_now;
    logic                  valid_w;
    logic                  irq_act;
    logic [DATA_W-1:0]     rdata_q;
    logic                  unused_wdata;

    assign unused_wdata = ^{wdata[DATA_W-1:FIELD_MSB+1], wdata[FIELD_LSB-1:0]};

    always_comb begin
        evt_vec          = '0;
        evt_vec[SRC_UPD] = evt_update;
        evt_vec[SRC_ALM] = evt_alarm;
        evt_vec[SRC_PER] = evt_periodic;
    end

    // address decode
    assign stat_rd  = rd_stb && (addr == ADR_STAT);
    assign valid_rd = rd_stb && (addr == ADR_VALID);
    assign ctrl_wr  = wr_stb && (addr == ADR_CTRL);

    rtcirq_hold_fsm #(.HOLD_LEN(HOLD_LEN)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_rd     (stat_rd),
        .holding     (holding),
        .release_now (release_now)
    );

    rtcirq_flag_bank u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt_vec),
        .clear       (stat_rd),
        .holding     (holding),
        .release_now (release_now),
        .flags       (flags_w)
    );

    rtcirq_valid_reg u_valid (
        .clk      (clk),
        .rst_n    (rst_n),
        .batt_low (batt_low),
        .valid_rd (valid_rd),
        .valid    (valid_w)
    );

    // enable mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (ctrl_wr) begin
            en_q <= wdata[FIELD_MSB:FIELD_LSB];
        end
    end

    assign irq_act = |(flags_w & en_q);

    // read data snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_stb) begin
            rdata_q <= '0;
            if (addr == ADR_CTRL) begin
                rdata_q[FIELD_MSB:FIELD_LSB] <= en_q;
            end else if (addr == ADR_STAT) begin
                rdata_q[SUM_BIT]             <= irq_act;
                rdata_q[FIELD_MSB:FIELD_LSB] <= flags_w;
            end else if (addr == ADR_VALID) begin
                rdata_q[VALID_BIT]           <= valid_w;
            end
        end
    end

    // outputs
    always_comb begin
        irq_n = !irq_act;
        rdata = rdata_q;
    end

endmodule

// File: rtl/rtcirq_ctrl_chk.sv
module rtcirq_ctrl_chk #(
    parameter int ADDR_W  = 2,
    parameter int A_CTRL  = 1,
    parameter int A_STAT  = 2,
    parameter int A_VALID = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic              irq_n,
    input logic              batt_low,
    input logic [2:0]        evt,
    input logic [2:0]        flags,
    input logic              holding,
    input logic              release_now,
    input logic              valid
);

    logic stat_rd, ctrl_wr, valid_rd;
    assign stat_rd  = rd_stb && (addr == ADDR_W'(A_STAT));
    assign ctrl_wr  = wr_stb && (addr == ADDR_W'(A_CTRL));
    assign valid_rd = rd_stb && (addr == ADDR_W'(A_VALID));

    p_event_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!holding && !stat_rd && evt != 3'b000) |=> ((flags & $past(evt)) == $past(evt)));

    p_summary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (rdata[7] == !$past(irq_n)));

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (flags == 3'b000));

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (holding && !release_now && !stat_rd) |=> $stable(flags));

    p_enable_immediate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !stat_rd && ((wdata[6:4] & flags) != 3'b000)) |=> !irq_n);

    p_valid_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_rd |=> (rdata[6:0] == 7'd0));

    p_batt_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        batt_low |=> !valid);

endmodule

bind rtcirq_ctrl rtcirq_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .A_CTRL  (A_CTRL),
    .A_STAT  (A_STAT),
    .A_VALID (A_VALID)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_stb      (rd_stb),
    .wr_stb      (wr_stb),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .irq_n       (irq_n),
    .batt_low    (batt_low),
    .evt         ({evt_periodic, evt_alarm, evt_update}),
    .flags       (flags_w),
    .holding     (holding),
    .release_now (release_now),
    .valid       (valid_w)
);

// File: tb/rtcirq_ctrl_tb.sv
module rtcirq_ctrl_tb;

    localparam int HOLD = 3;
    localparam logic [1:0] AU = 2'd0, AC = 2'd1, AS = 2'd2, AV = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ev = 3'b000;       // [2] periodic, [1] alarm, [0] update
    logic       batt_low = 1'b0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rtcirq_ctrl #(.HOLD_LEN(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_alarm(ev[1]), .evt_periodic(ev[2]), .evt_update(ev[0]),
        .batt_low(batt_low), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
    );

    // bench reference model built from the requirements
    logic [2:0] m_flag, m_pend, m_en;
    logic       m_hold, m_valid;
    int         m_cnt;
    logic [7:0] m_rdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 0; m_pend = 0; m_en = 0; m_hold = 0; m_valid = 0;
            m_cnt = 0; m_rdata = 0;
        end else begin
            if (rd_stb) begin
                case (addr)
                    AC:      m_rdata = {1'b0, m_en, 4'h0};
                    AS:      m_rdata = {|(m_flag & m_en), m_flag, 4'h0};
                    AV:      m_rdata = {m_valid, 7'h00};
                    default: m_rdata = 8'h00;
                endcase
            end
            if (wr_stb && addr == AC) m_en = wdata[6:4];
            if (batt_low) m_valid = 1'b0;
            else if (rd_stb && addr == AV) m_valid = 1'b1;
            if (rd_stb && addr == AS) begin
                m_pend = m_pend | ev; m_flag = 0; m_hold = 1; m_cnt = 0;
            end else if (m_hold) begin
                if (m_cnt == HOLD - 1) begin
                    m_flag = m_flag | m_pend | ev; m_pend = 0; m_hold = 0;
                end else begin
                    m_pend = m_pend | ev; m_cnt = m_cnt + 1;
                end
            end else begin
                m_flag = m_flag | ev;
            end
        end
    end

    function automatic logic exp_irq_n();
        return !(|(m_flag & m_en));
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_stb = 1'b1; addr = a;
        @(negedge clk);
        rd_stb = 1'b0;
        d = rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_stb = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] v);
        ev = v;
        @(negedge clk);
        ev = 3'b000;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R3 irq_n after reset", {7'd0, irq_n}, 8'h01);
        rd(AS, d); check("R4 status after reset", d, 8'h00);
        idle(5);
        rd(AV, d); check("R8 valid after reset", d, 8'h00);
        rd(AV, d); check("R9 valid set by read", d, 8'h80);

        // flag without enable, then enable afterwards
        pulse(3'b010);
        check("R1 alarm flag, disabled irq", {7'd0, irq_n}, 8'h01);
        rd(AC, d); check("R2 ctrl reset", d, 8'h00);
        wr(AC, 8'h20);
        check("R7 enable with pending flag", {7'd0, irq_n}, 8'h00);
        rd(AS, d); check("R4 status summary+alarm", d, 8'hA0);
        check("R5 irq released after read", {7'd0, irq_n}, 8'h01);
        idle(5);
        rd(AS, d); check("R5 flags cleared", d, 8'h00);
        idle(5);

        // event inside the hold window
        wr(AC, 8'h70);
        rd(AS, d); check("R5 empty status", d, 8'h00);
        pulse(3'b100);
        check("R6 held at window cycle 1", {7'd0, irq_n}, 8'h01);
        idle(1);
        check("R6 held at window cycle 2", {7'd0, irq_n}, 8'h01);
        idle(1);
        check("R6 released at window end", {7'd0, irq_n}, 8'h00);
        rd(AS, d); check("R6 periodic after release", d, 8'hC0);
        idle(5);

        // event in the read cycle itself
        rd_stb = 1'b1; addr = AS; ev = 3'b001;
        @(negedge clk);
        rd_stb = 1'b0; ev = 3'b000;
        check("R6 read-cycle snapshot", rdata, 8'h00);
        idle(2);
        check("R6 read-cycle event held", {7'd0, irq_n}, 8'h01);
        idle(1);
        check("R6 read-cycle event released", {7'd0, irq_n}, 8'h00);
        rd(AS, d); check("R6 update flag", d, 8'h90);
        idle(5);

        // restart of the window by a second read
        rd(AS, d);
        rd(AS, d); check("R6 second read", d, 8'h00);
        pulse(3'b001);
        idle(1);
        check("R6 restart keeps hold", {7'd0, irq_n}, 8'h01);
        idle(1);
        check("R6 restart releases", {7'd0, irq_n}, 8'h00);
        rd(AS, d); check("R6 flag after restart", d, 8'h90);
        idle(5);

        // control register field isolation
        wr(AC, 8'hFF);
        rd(AC, d); check("R2 only enable bits stored", d, 8'h70);
        wr(AC, 8'h00);

        // valid register handling
        wr(AV, 8'h00);
        rd(AV, d); check("R8 write to valid ignored", d, 8'h80);
        batt_low = 1'b1; @(negedge clk); batt_low = 1'b0;
        rd(AV, d); check("R9 battery low clears", d, 8'h00);
        batt_low = 1'b1;
        rd(AV, d);
        batt_low = 1'b0;
        rd(AV, d); check("R9 battery low beats read", d, 8'h00);
        rd(AV, d); check("R9 set again", d, 8'h80);

        // unmapped address
        wr(AU, 8'hFF);
        rd(AU, d); check("R10 unmapped read", d, 8'h00);
        rd(AC, d); check("R10 ctrl untouched", d, 8'h00);

        // summary stays 0 when flag is masked
        pulse(3'b100);
        rd(AS, d); check("R4 masked summary", d, 8'h40);
        idle(5);

        // constrained random traffic against the model
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            logic did_rd;
            ev       = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
            did_rd   = (($urandom % 5) == 0);
            rd_stb   = did_rd;
            wr_stb   = (($urandom % 8) == 0);
            addr     = 2'($urandom);
            wdata    = 8'($urandom);
            batt_low = (($urandom % 32) == 0);
            @(negedge clk);
            check("R3 random irq_n", {7'd0, irq_n}, {7'd0, exp_irq_n()});
            if (did_rd) check("R1 R4 R5 R9 random rdata", rdata, m_rdata);
        end
        ev = 0; rd_stb = 0; wr_stb = 0; batt_low = 0;
        idle(2);
        finish_run();
    end

endmodule